// File: doc/BRIEF.md
# Sound Generator Host Register Interface

This block is the host-side register file of a three-voice sound generator. A host drives a 5-bit register address, an 8-bit data byte and a write enable. Each write is steered into one byte of the voice or filter configuration. The stored bytes leave the block as wide fields that the voice and filter logic use directly. Each write also raises a one-cycle strobe for the register it hit, in the same cycle as the write.

Reads are combinational from the address. Two locations return live bytes from voice 3: the oscillator value and the envelope value. Two potentiometer locations always read zero. Every other location is write-only and reads back the last byte written, from any address. That byte is held in a bus latch, which clears itself after a fixed number of cycles with no write.

Top module: `snd_regbus`

## Requirements
- R1: Each voice v (0..2) owns seven bytes starting at address 7*v. The offsets are +0 frequency low, +1 frequency high, +2 pulse width low, +3 pulse width high, +4 control, +5 attack/decay and +6 sustain/release. After the write edge they appear on `freq_v[16v+:16]` and `pw_v[16v+:16]` (high byte in bits 15:8), `ctrl_v[8v+:8]`, `atkdec_v[8v+:8]` and `susrel_v[8v+:8]`.
- R2: Address 0x15 loads `cutoff[7:0]` and 0x16 loads `cutoff[15:8]`. Address 0x17 loads `resrout` and 0x18 loads `modevol`.
- R3: While `wr_en` is high, `reg_stb[a]` is high in that same cycle for the written address a in 0x00..0x18. Any other address raises no strobe, and at most one strobe is ever high.
- R4: Every write, to any address 0x00..0x1F, loads the data byte into the bus latch and sets the decay counter to TTL_INIT (default 8192).
- R5: While no write occurs, the decay counter drops by one per clock. The latch keeps its byte for TTL_INIT-1 edges after the write edge and reads 0 from the TTL_INIT-th edge on.
- R6: Reads of 0x19 and 0x1A return 0.
- R7: Reads of 0x1B return `osc3_in` and reads of 0x1C return `env3_in`, combinationally.
- R8: Reads of 0x00..0x18 and 0x1D..0x1F return the bus latch.
- R9: Writes to 0x19..0x1F change no configuration output.
- R10: Reset (active-low `rst_n`) clears the bus latch, the decay counter and every configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write enable |
| addr | input | 5 | register address for read and write |
| wdata | input | 8 | write data |
| osc3_in | input | 8 | live oscillator byte of voice 3 |
| env3_in | input | 8 | live envelope byte of voice 3 |
| rd_data | output | 8 | read data for `addr` |
| freq_v | output | 48 | frequency words, 16 bits per voice |
| pw_v | output | 48 | pulse width words, 16 bits per voice |
| ctrl_v | output | 24 | control bytes |
| atkdec_v | output | 24 | attack/decay bytes |
| susrel_v | output | 24 | sustain/release bytes |
| cutoff | output | 16 | filter cutoff word |
| resrout | output | 8 | resonance and routing byte |
| modevol | output | 8 | mode and volume byte |
| reg_stb | output | 25 | one-hot write strobe per configuration register |

## Verification
The assertions check on every cycle that a write reloads the latch and counter, that the counter counts down one step per idle cycle, and that the latch is zero once the counter is zero. They also check that strobes are one-hot, that read-only and unused writes leave the configuration stable, and that the potentiometer and voice-3 reads are correct. The bench's scenarios are needed to show that each address reaches its own output field and that the latch survives exactly TTL_INIT-1 idle edges. They also show that a rewrite refreshes the decay window and that a mid-run reset clears everything.

// File: rtl/snd_regbus.sv
module snd_regbus #(
  parameter int NVOICE   = 3,
  parameter int VREGS    = 7,
  parameter int TTL_INIT = 8192
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [4:0]                addr,
  input  logic [7:0]                wdata,
  input  logic [7:0]                osc3_in,
  input  logic [7:0]                env3_in,
  output logic [7:0]                rd_data,
  output logic [NVOICE*16-1:0]      freq_v,
  output logic [NVOICE*16-1:0]      pw_v,
  output logic [NVOICE*8-1:0]       ctrl_v,
  output logic [NVOICE*8-1:0]       atkdec_v,
  output logic [NVOICE*8-1:0]       susrel_v,
  output logic [15:0]               cutoff,
  output logic [7:0]                resrout,
  output logic [7:0]                modevol,
  output logic [NVOICE*VREGS+3:0]   reg_stb
);
  localparam int FBASE = NVOICE * VREGS;
  localparam int NREG  = FBASE + 4;
  localparam int TW    = $clog2(TTL_INIT + 1);
  localparam logic [4:0] A_POTA = 5'(NREG);
  localparam logic [4:0] A_POTB = 5'(NREG + 1);
  localparam logic [4:0] A_OSC  = 5'(NREG + 2);
  localparam logic [4:0] A_ENV  = 5'(NREG + 3);

  logic [NREG-1:0][7:0] regf;
  logic [7:0]           latch_q;
  logic [TW-1:0]        ttl_q;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      assign reg_stb[g] = wr_en && (addr == 5'(g));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          regf[g] <= '0;
        else if (reg_stb[g]) regf[g] <= wdata;
    end
    for (g = 0; g < NVOICE; g++) begin : g_voice
      assign freq_v[16*g +: 16] = {regf[VREGS*g+1], regf[VREGS*g+0]};
      assign pw_v[16*g +: 16]   = {regf[VREGS*g+3], regf[VREGS*g+2]};
      assign ctrl_v[8*g +: 8]   = regf[VREGS*g+4];
      assign atkdec_v[8*g +: 8] = regf[VREGS*g+5];
      assign susrel_v[8*g +: 8] = regf[VREGS*g+6];
    end
  endgenerate

  assign cutoff  = {regf[FBASE+1], regf[FBASE]};
  assign resrout = regf[FBASE+2];
  assign modevol = regf[FBASE+3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      ttl_q   <= '0;
    end else if (wr_en) begin
      latch_q <= wdata;
      ttl_q   <= TW'(TTL_INIT);
    end else if (ttl_q != '0) begin
      ttl_q <= ttl_q - 1'b1;
      if (ttl_q == TW'(1)) latch_q <= '0;
    end
  end

  always_comb begin
    case (addr)
      A_POTA, A_POTB: rd_data = '0;
      A_OSC:          rd_data = osc3_in;
      A_ENV:          rd_data = env3_in;
      default:        rd_data = latch_q;
    endcase
  end

  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (latch_q == $past(wdata)) && (ttl_q == TW'(TTL_INIT)));
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ttl_q != '0) |=> ttl_q == $past(ttl_q) - 1'b1);
  a_r5_dead_latch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ttl_q == '0) |-> latch_q == '0);
  a_r3_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_stb));
  a_r3_stb_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> reg_stb == '0);
  a_r9_ro_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= 5'(NREG)) |=> $stable(regf));
  a_r6_pot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_POTA || addr == A_POTB) |-> rd_data == '0);
  a_r7_live_osc: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_OSC) |-> rd_data == osc3_in);
  a_r7_live_env: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ENV) |-> rd_data == env3_in);
endmodule

// File: tb/sim_snd_regbus.sv
module sim_snd_regbus;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, osc3_in = 0, env3_in = 0;
  logic [7:0] rd_data;
  logic [47:0] freq_v, pw_v;
  logic [23:0] ctrl_v, atkdec_v, susrel_v;
  logic [15:0] cutoff;
  logic [7:0] resrout, modevol;
  logic [24:0] reg_stb;

  int n_chk = 0, n_bad = 0;

  snd_regbus u0 (.clk, .rst_n, .wr_en, .addr, .wdata, .osc3_in, .env3_in,
    .rd_data, .freq_v, .pw_v, .ctrl_v, .atkdec_v, .susrel_v, .cutoff,
    .resrout, .modevol, .reg_stb);

  always #5 clk = ~clk;

  logic [7:0] m_reg [0:24];
  logic [7:0] m_latch;
  int         m_ttl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 25; i++) m_reg[i] <= 8'h00;
      m_latch <= 8'h00; m_ttl <= 0;
    end else if (wr_en) begin
      if (addr < 25) m_reg[addr] <= wdata;
      m_latch <= wdata; m_ttl <= 8192;
    end else if (m_ttl > 0) begin
      m_ttl <= m_ttl - 1;
      if (m_ttl == 1) m_latch <= 8'h00;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h19, 5'h1A: return 8'h00;
      5'h1B: return osc3_in;
      5'h1C: return env3_in;
      default: return m_latch;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_fields(input string req);
    for (int v = 0; v < 3; v++) begin
      chk({req, " R1 freq"}, 64'(freq_v[16*v +: 16]), 64'({m_reg[7*v+1], m_reg[7*v]}));
      chk({req, " R1 pw"},   64'(pw_v[16*v +: 16]),   64'({m_reg[7*v+3], m_reg[7*v+2]}));
      chk({req, " R1 ctrl"}, 64'(ctrl_v[8*v +: 8]),   64'(m_reg[7*v+4]));
      chk({req, " R1 ad"},   64'(atkdec_v[8*v +: 8]), 64'(m_reg[7*v+5]));
      chk({req, " R1 sr"},   64'(susrel_v[8*v +: 8]), 64'(m_reg[7*v+6]));
    end
    chk({req, " R2 cutoff"}, 64'(cutoff), 64'({m_reg[22], m_reg[21]}));
    chk({req, " R2 res"},    64'(resrout), 64'(m_reg[23]));
    chk({req, " R2 modevol"},64'(modevol), 64'(m_reg[24]));
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    #1;
    chk("R3 strobe", 64'(reg_stb), (a < 25) ? (64'd1 << a) : 64'd0);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(input logic [4:0] a, input string req);
    @(negedge clk); addr = a; osc3_in = 8'($urandom); env3_in = 8'($urandom);
    #1;
    chk(req, 64'(rd_data), 64'(exp_rd(a)));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset rd", 64'(rd_data), 64'h0);
    chk_fields("R10 reset");
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < 32; a++) begin
      do_write(5'(a), 8'(a * 7 + 3));
      #1; chk_fields("R1/R2/R9 sweep");
      do_read(5'(a), "R4/R8 sweep read");
    end
    do_read(5'h19, "R6 pot x"); do_read(5'h1A, "R6 pot y");
    do_read(5'h1B, "R7 osc3");  do_read(5'h1C, "R7 env3");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      a = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else do_read(a, "R6/R7/R8 random read");
      repeat ($urandom_range(0, 3)) @(negedge clk);
      #1; chk_fields("R1/R2/R9 random");
    end

    do_write(5'h1F, 8'h5A);
    repeat (8191) @(posedge clk);
    @(negedge clk); addr = 5'h03; #1;
    chk("R5 latch alive at TTL-1", 64'(rd_data), 64'h5A);
    @(negedge clk); #1;
    chk("R5 latch cleared at TTL", 64'(rd_data), 64'h00);

    do_write(5'h10, 8'hC3);
    repeat (5000) @(posedge clk);
    do_write(5'h1D, 8'h77);
    repeat (7000) @(posedge clk);
    @(negedge clk); addr = 5'h1E; #1;
    chk("R4 rewrite refreshes window", 64'(rd_data), 64'h77);
    chk("R9 unused write kept pw", 64'(pw_v[32 +: 16]), 64'({m_reg[17], 8'hC3}));

    do_write(5'h18, 8'h9F);
    @(negedge clk); rst_n = 0; #1;
    chk("R10 mid reset latch", 64'(rd_data), 64'h00);
    chk("R10 mid reset modevol", 64'(modevol), 64'h00);
    @(negedge clk); rst_n = 1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule